// File: doc/BRIEF.md
# Gshare Direction Predictor with PC-Only Low Index Bits

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. Each entry is selected by an index built from the branch's program-counter word bits and a register of recent branch outcomes. The lowest three index bits come straight from the PC. The upper index bits are the PC bits XORed with the outcome history. Branches that sit close together in the code therefore never collide in the low index bits, whatever the history holds.

A fetch stage presents the word-address part of the PC on the lookup port. In the same cycle it receives a direction and the table index that produced it. The index travels down the pipeline with the branch. At resolution the back end hands that index back with the real outcome and the direction that was predicted. The block then trains the counter, shifts the outcome into the history, and reports a fixed drain penalty for a wrong guess on a count output.

After reset the block walks through every table entry, one entry per cycle, and loads the weakly not-taken value. A busy flag stays high while it does so. The production size is a 14-bit index, which gives 16K entries.

Top module: `bp_gshare_top`

## Requirements
- R1: Index bits [2:0] equal PC bits [4:2], which are bits [2:0] of the `lk_pca` port, with no history mixed in; `lk_idx` shows the index in the same cycle as the lookup.
- R2: Index bits [IDX_W-1:3] equal PC bits [IDX_W+1:5], which are `lk_pca[IDX_W-1:3]`, XORed bit for bit with the (IDX_W-3)-bit history.
- R3: `lk_taken` is the most significant bit of the counter at `lk_idx`, in the same cycle as the lookup: the values 2 and 3 predict taken, and 0 and 1 predict not taken.
- R4: An accepted update adds one to the counter at `up_idx` when the outcome is taken and subtracts one when it is not taken, and the counter holds at 0 and at 3.
- R5: Each accepted update shifts the history left by one bit and puts the outcome in bit 0 (1 for taken, 0 for not taken). Without an accepted update the history does not change.
- R6: A cycle with `rst` high clears the history to zero and raises `busy`. After `rst` falls, `busy` stays high for exactly 2^IDX_W cycles while every counter is loaded with 1 (weakly not taken). While `busy` is high, `lk_taken` is 0.
- R7: When a lookup and an update select the same entry in one cycle, the lookup returns the counter value from before that update.
- R8: In the cycle after an accepted update whose `up_pred` differs from `up_taken`, `drain_cycles` equals DRAIN (default 8). In every other cycle, including during reset, it is 0.
- R9: An update presented while `busy` is high is ignored. It changes no counter and does not shift the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pca | input | IDX_W | Lookup PC word bits [IDX_W+1:2] |
| lk_idx | output | IDX_W | Table index used for this lookup |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Update request |
| up_idx | input | IDX_W | Index returned by the lookup of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_pred | input | 1 | Direction that was predicted for that branch |
| busy | output | 1 | Table initialisation in progress |
| drain_cycles | output | $clog2(DRAIN+1) | Penalty count for the previous cycle's update |

## Verification
The bench builds the block with IDX_W=6, which gives 64 counters and 3 history bits, and with DRAIN=8. With so few history bits, the history wraps after a handful of updates. Random lookups and updates over 64 PC values then make different PC and history pairs land on the same entry, and they make lookups and updates select the same entry in the same cycle. Both cases are frequent. The 64-cycle table clear is short enough for the bench to repeat it in the middle of the run with updates applied during it. Counters are driven to both saturation limits with directed runs of taken and not-taken outcomes.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  // saturating 2-bit step toward the observed outcome
  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : ctr_t'(c + 2'b01);
    else       return (c == 2'b00) ? c : ctr_t'(c - 2'b01);
  endfunction
endpackage

// File: rtl/bp_index_hash.sv
module bp_index_hash #(
  parameter int IDX_W = 11,
  parameter int LOW_W = 3,
  localparam int HIST_W = IDX_W - LOW_W
) (
  input  logic [IDX_W-1:0]  pca,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  generate
    if (LOW_W > 0) begin : g_split
      always_comb idx = {pca[IDX_W-1:LOW_W] ^ hist, pca[LOW_W-1:0]};
    end else begin : g_full
      always_comb idx = pca ^ hist;
    end
  endgenerate
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  generate
    if (HIST_W > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
      end
    end else begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= bit_in;
      end
    end
  endgenerate

  // history only moves on an accepted update
  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken,
  output logic             busy
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  ctr_t             mem [DEPTH];
  logic [IDX_W-1:0] clr_ptr;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  ctr_t             wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b1;
      clr_ptr <= '0;
    end else if (busy) begin
      clr_ptr <= clr_ptr + 1'b1;
      if (clr_ptr == LAST) busy <= 1'b0;
    end
  end

  // one write port: the clear walk has priority over training
  always_comb begin
    wr_en   = busy | up_en;
    wr_addr = busy ? clr_ptr : up_idx;
    wr_data = busy ? CTR_WEAK_NT : ctr_step(mem[up_idx], up_taken);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read sees the value before this cycle's write
  assign rd_ctr = mem[rd_idx];

  assert_clear_walk_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && clr_ptr != LAST) |=> (busy && clr_ptr == IDX_W'($past(clr_ptr) + 1'b1)));

  assert_sat_top_R4: assert property (@(posedge clk) disable iff (rst)
    (up_en && !busy && up_taken && mem[up_idx] == 2'b11) |=> mem[$past(up_idx)] == 2'b11);

  assert_sat_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (up_en && !busy && !up_taken && mem[up_idx] == 2'b00) |=> mem[$past(up_idx)] == 2'b00);
endmodule

// File: rtl/bp_gshare_top.sv
module bp_gshare_top
  import bp_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int LOW_W = 3,
  parameter int DRAIN = 8,
  localparam int HIST_W = IDX_W - LOW_W,
  localparam int CNT_W  = $clog2(DRAIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_pca,
  output logic [IDX_W-1:0] lk_idx,
  output logic             lk_taken,
  input  logic             up_valid,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken,
  input  logic             up_pred,
  output logic             busy,
  output logic [CNT_W-1:0] drain_cycles
);
  logic [HIST_W-1:0] hist;
  ctr_t              rd_ctr;
  logic              accept;

  assign accept = up_valid & ~busy;

  bp_index_hash #(.IDX_W(IDX_W), .LOW_W(LOW_W)) u_hash (
    .pca(lk_pca), .hist(hist), .idx(lk_idx)
  );

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(accept), .bit_in(up_taken), .hist(hist)
  );

  bp_ctr_table #(.IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst(rst), .rd_idx(lk_idx), .rd_ctr(rd_ctr),
    .up_en(accept), .up_idx(up_idx), .up_taken(up_taken), .busy(busy)
  );

  assign lk_taken = ~busy & rd_ctr[1];

  always_ff @(posedge clk) begin
    if (rst) drain_cycles <= '0;
    else     drain_cycles <= (accept && up_pred != up_taken) ? CNT_W'(DRAIN) : '0;
  end

  assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !lk_taken);

  assert_low_bits_R1: assert property (@(posedge clk) disable iff (rst)
    (hist == '0) |-> (lk_idx == lk_pca));

  assert_drain_value_R8: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !busy && up_pred != up_taken) |=> drain_cycles == CNT_W'(DRAIN));

  assert_drain_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> drain_cycles == '0);
endmodule

// File: tb/sim_bp_gshare_top.sv
`timescale 1ns/1ps
module sim_bp_gshare_top;
  localparam int IW = 6;
  localparam int DEPTH = 1 << IW;
  localparam int DR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] lk_pca = '0;
  logic [IW-1:0] lk_idx;
  logic lk_taken;
  logic up_valid = 1'b0;
  logic [IW-1:0] up_idx = '0;
  logic up_taken = 1'b0;
  logic up_pred = 1'b0;
  logic busy;
  logic [3:0] drain_cycles;

  int checks = 0;
  int errors = 0;

  int ctr [DEPTH];
  int hist = 0;
  int clr_left = DEPTH;
  int exp_drain = 0;

  always #10 clk = ~clk;

  bp_gshare_top #(.IDX_W(IW), .LOW_W(3), .DRAIN(DR)) u0 (
    .clk(clk), .rst(rst), .lk_pca(lk_pca), .lk_idx(lk_idx), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken), .up_pred(up_pred),
    .busy(busy), .drain_cycles(drain_cycles)
  );

  function automatic int model_idx(int pca);
    return ((((pca >> 3) ^ hist) & 7) << 3) | (pca & 7);
  endfunction

  function automatic int pca_for(int target);
    return ((((target >> 3) ^ hist) & 7) << 3) | (target & 7);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // called at a negative edge: drive, check, then advance the model at the posedge
  task automatic cycle(int pca, bit uv, int uidx, bit ut, bit up, string tag);
    bit mb;
    int ei;
    int ep;
    lk_pca = IW'(pca); up_valid = uv; up_idx = IW'(uidx); up_taken = ut; up_pred = up;
    #1;
    mb = (clr_left > 0);
    ei = model_idx(pca);
    ep = mb ? 0 : (ctr[ei] >> 1);
    chk(busy == mb, "R6", "busy", busy, mb);
    chk(lk_idx == IW'(ei), (hist == 0) ? "R1" : "R2 R5", "lk_idx", lk_idx, ei);
    chk(lk_taken == ep[0], tag, "lk_taken", lk_taken, ep);
    chk(drain_cycles == 4'(exp_drain), "R8", "drain_cycles", drain_cycles, exp_drain);
    @(posedge clk);
    if (uv && !mb) begin
      if (ut && ctr[uidx] < 3) ctr[uidx]++;
      if (!ut && ctr[uidx] > 0) ctr[uidx]--;
      hist = ((hist << 1) | int'(ut)) & 7;
      exp_drain = (up != ut) ? DR : 0;
    end else begin
      exp_drain = 0;
    end
    if (clr_left > 0) clr_left--;
    @(negedge clk);
  endtask

  task automatic do_reset();
    int p;
    p = 37;
    rst = 1'b1; up_valid = 1'b0; lk_pca = IW'(p);
    repeat (2) @(posedge clk);
    @(negedge clk);
    hist = 0; clr_left = DEPTH; exp_drain = 0;
    foreach (ctr[i]) ctr[i] = 1;
    chk(busy == 1'b1, "R6", "busy in reset", busy, 1);
    chk(drain_cycles == 4'd0, "R8", "drain in reset", drain_cycles, 0);
    chk(lk_taken == 1'b0, "R6", "pred in reset", lk_taken, 0);
    chk(lk_idx == IW'(p), "R6", "history cleared", lk_idx, p);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // clear walk, with updates that must be dropped
    for (int i = 0; i < DEPTH; i++)
      cycle(i, 1'b1, i, 1'b1, 1'b0, "R9");
    // history still zero, all counters weak not taken
    for (int i = 0; i < DEPTH; i++)
      cycle(i, 1'b0, 0, 1'b0, 1'b0, "R9");
    // same-entry lookup and update in one cycle
    cycle(5, 1'b1, 5, 1'b1, 1'b0, "R7");
    cycle(pca_for(5), 1'b1, 5, 1'b1, 1'b1, "R7");
    // climb to the ceiling and hold there
    for (int i = 0; i < 5; i++)
      cycle(pca_for(5), 1'b1, 5, 1'b1, 1'b1, "R4");
    cycle(pca_for(5), 1'b0, 0, 1'b0, 1'b0, "R4");
    // fall to the floor and hold there
    for (int i = 0; i < 6; i++)
      cycle(pca_for(5), 1'b1, 5, 1'b0, 1'b1, "R4");
    cycle(pca_for(5), 1'b0, 0, 1'b0, 1'b0, "R4");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int p;
      int u;
      p = $urandom_range(0, DEPTH - 1);
      u = ($urandom_range(0, 3) == 0) ? model_idx(p) : $urandom_range(0, DEPTH - 1);
      cycle(p, 1'($urandom_range(0, 1)), u, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), "R3");
    end
    // reset in mid-run, then confirm the table was reloaded
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      cycle(DEPTH - 1 - i, 1'b1, i, 1'b0, 1'b1, "R9");
    for (int i = 0; i < DEPTH; i++)
      cycle(i, 1'b0, 0, 1'b0, 1'b0, "R6");
    summary();
  end
endmodule